// File: doc/BRIEF.md
# Zero-Substitution Bipolar Line Encoder

This block turns a single-rail NRZ bit stream into a pair of registered pulse enables, one for positive and one for negative line pulses, for a bipolar line driver. Marks alternate in polarity (AMI). Long zero runs are replaced with code words that carry a deliberate polarity violation: three-zero substitution for the DS3/STS-1 rates and four-zero substitution for the E3 rate. Substitution can be switched off, which leaves plain AMI.

A dual-rail mode lets externally coded positive and negative data pass through unchanged with the same latency. A transmit-all-ones override sends a continuous alternating mark stream whatever the data. A transmitter-off control forces both outputs inactive and stands in for a tri-stated line. Data is sampled either on the falling or the rising clock edge. Every other control is taken on the rising edge. The encoder works through a fixed look-ahead window of `WIN` stages, so the output latency does not depend on the mode.

Top module: `zs_line_encoder`

## Requirements
- R1: With `sel_e3`=0 and `subst_dis`=0, every run of three zeros is sent as 00V when an odd number of marks has entered since the last substitution, and as B0V when that number is even. B is the first slot of the run and V is the third.
- R2: With `sel_e3`=1 and `subst_dis`=0, every run of four zeros is sent as 000V (odd mark count) or B00V (even mark count). B is the first slot of the run and V is the fourth.
- R3: Ordinary marks and B pulses take the polarity opposite to the previous pulse. A V pulse repeats the polarity of the previous pulse. After reset the first pulse is positive, and the mark count starts at zero (even).
- R4: With `subst_dis`=1 the output is plain AMI: zeros give no pulse and marks alternate.
- R5: In single-rail mode (`dual_rail`=0) the `tx_n` input has no effect on the outputs.
- R6: With `dual_rail`=1, `out_p`/`out_n` equal the sampled `tx_p`/`tx_n` with the same latency as the encoded path.
- R7: A bit sampled at rising edge k is reflected on the outputs right after rising edge k+4 (`WIN`=4) in every mode. The mark count and the zero window are kept across mode changes.
- R8: With `edge_rise`=0 the data taken is the value present at the falling edge before rising edge k. With `edge_rise`=1 it is the value present at rising edge k.
- R9: With `all_ones`=1 the data inputs are ignored and each sampled bit is a mark, which gives a continuous alternating pulse stream.
- R10: With `tx_off`=1 at a rising edge, both outputs are low after that edge. The encoder state keeps advancing.
- R11: While `rst`=1 (synchronous, active high) both outputs are low after each edge.
- R12: Outside dual-rail mode, `out_p` and `out_n` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_p | input | 1 | Single-rail data, or positive rail in dual-rail mode |
| tx_n | input | 1 | Negative rail in dual-rail mode; ignored otherwise |
| sel_e3 | input | 1 | 1: four-zero substitution; 0: three-zero substitution |
| subst_dis | input | 1 | 1: no substitution (plain AMI) |
| dual_rail | input | 1 | 1: pass sampled rails straight through |
| all_ones | input | 1 | 1: send continuous marks |
| tx_off | input | 1 | 1: force both outputs low |
| edge_rise | input | 1 | 1: sample data on rising edge; 0: falling edge |
| out_p | output | 1 | Registered positive pulse enable |
| out_n | output | 1 | Registered negative pulse enable |

## Verification
The hardest internal states to observe are the polarity flag and the mark-count parity. A wrong polarity flag inverts the pulse pair on the next mark, at most WIN+1 cycles after the fault. A wrong parity bit shows up only at the next complete zero run, as a missing or extra B pulse, and it then shifts the polarity of every later pulse. The bench therefore mixes sparse random data, which produces many substitutions, with mode switches in the middle of a stream. A reference model compares both rails every cycle, so a divergence is caught in the first cycle it reaches the ports.

// File: rtl/zs_enc_pkg.sv
package zs_enc_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2
  } sym_e;

  localparam int SHORT_RUN = 3;
  localparam int LONG_RUN  = 4;
endpackage

// File: rtl/zs_edge_sample.sv
module zs_edge_sample #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] fall_q;

  // falling-edge capture; the rising-edge path uses din directly at the next posedge register
  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= din;
  end

  assign dout = rise_sel ? din : fall_q;
endmodule

// File: rtl/zs_subst_window.sv
module zs_subst_window
  import zs_enc_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic sel_long,
  input  logic subst_dis,
  output sym_e sym_out
);
  sym_e sr [WIN];
  logic odd;
  logic all_zero;
  logic fire;
  int   run_len;

  always_comb begin
    run_len  = sel_long ? LONG_RUN : SHORT_RUN;
    all_zero = 1'b1;
    for (int i = 0; i < WIN - 1; i++) begin
      if (i < run_len - 1 && sr[i] != SYM_ZERO) all_zero = 1'b0;
    end
    fire = !bit_in && !subst_dis && all_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) sr[i] <= SYM_ZERO;
      odd <= 1'b0;
    end else begin
      sr[0] <= bit_in ? SYM_MARK : (fire ? SYM_VIOL : SYM_ZERO);
      for (int i = 1; i < WIN; i++) begin
        sr[i] <= (fire && !odd && i == run_len - 1) ? SYM_MARK : sr[i-1];
      end
      if (fire)        odd <= 1'b0;
      else if (bit_in) odd <= ~odd;
    end
  end

  assign sym_out = sr[WIN-1];

  // R4: with substitution off, a zero never enters as a violation
  a_r4_no_viol_when_off: assert property (@(posedge clk) disable iff (rst)
    (subst_dis && !bit_in) |=> (sr[0] == SYM_ZERO));
endmodule

// File: rtl/zs_delay_line.sv
module zs_delay_line #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/zs_polarizer.sv
module zs_polarizer
  import zs_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sym_e sym,
  input  logic raw_p,
  input  logic raw_n,
  input  logic dual,
  input  logic off,
  output logic out_p,
  output logic out_n
);
  logic last_pos;
  logic enc_p;
  logic enc_n;

  always_comb begin
    enc_p = (sym == SYM_MARK && !last_pos) || (sym == SYM_VIOL && last_pos);
    enc_n = (sym == SYM_MARK && last_pos)  || (sym == SYM_VIOL && !last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos <= 1'b0;
      out_p    <= 1'b0;
      out_n    <= 1'b0;
    end else begin
      if (sym == SYM_MARK) last_pos <= ~last_pos;
      if (off) begin
        out_p <= 1'b0;
        out_n <= 1'b0;
      end else if (dual) begin
        out_p <= raw_p;
        out_n <= raw_n;
      end else begin
        out_p <= enc_p;
        out_n <= enc_n;
      end
    end
  end
endmodule

// File: rtl/zs_line_encoder.sv
module zs_line_encoder
  import zs_enc_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_p,
  input  logic tx_n,
  input  logic sel_e3,
  input  logic subst_dis,
  input  logic dual_rail,
  input  logic all_ones,
  input  logic tx_off,
  input  logic edge_rise,
  output logic out_p,
  output logic out_n
);
  localparam int CW = $clog2(WIN + 3);

  logic [1:0] samp;
  logic [1:0] raw_dly;
  logic       enc_bit;
  sym_e       sym_tail;

  zs_edge_sample #(.W(2)) u_sample (
    .clk(clk), .rst(rst), .rise_sel(edge_rise),
    .din({tx_p, tx_n}), .dout(samp)
  );

  assign enc_bit = all_ones | samp[1];

  zs_subst_window #(.WIN(WIN)) u_window (
    .clk(clk), .rst(rst), .bit_in(enc_bit), .sel_long(sel_e3),
    .subst_dis(subst_dis), .sym_out(sym_tail)
  );

  zs_delay_line #(.W(2), .DEPTH(WIN)) u_raw (
    .clk(clk), .rst(rst), .din(samp), .dout(raw_dly)
  );

  zs_polarizer u_pol (
    .clk(clk), .rst(rst), .sym(sym_tail),
    .raw_p(raw_dly[1]), .raw_n(raw_dly[0]),
    .dual(dual_rail), .off(tx_off),
    .out_p(out_p), .out_n(out_n)
  );

  // run length of the all-ones override, used only by the checks below
  logic [CW-1:0] ones_cnt;
  always_ff @(posedge clk) begin
    if (rst || !all_ones)          ones_cnt <= '0;
    else if (ones_cnt != CW'(WIN + 2)) ones_cnt <= ones_cnt + CW'(1);
  end

  // R10
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
    tx_off |=> (!out_p && !out_n));

  // R12
  a_r12_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
    !dual_rail |=> !(out_p && out_n));

  // R11
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_p && !out_n));

  // R9: one pulse every cycle once the override has filled the window
  a_r9_ones_pulse: assert property (@(posedge clk) disable iff (rst)
    (ones_cnt >= CW'(WIN + 1) && !$past(tx_off) && !$past(dual_rail))
      |-> (out_p != out_n));

  // R9: consecutive pulses alternate
  a_r9_ones_alternate: assert property (@(posedge clk) disable iff (rst)
    (ones_cnt >= CW'(WIN + 2) && !$past(tx_off) && !$past(dual_rail)
      && !$past(tx_off, 2) && !$past(dual_rail, 2))
      |-> (out_p != $past(out_p)));
endmodule

// File: tb/zs_line_encoder_test.sv
`timescale 1ns/1ps
module zs_line_encoder_test;
  localparam int WIN = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic tx_p = 0, tx_n = 0, sel_e3 = 0, subst_dis = 0, dual_rail = 0;
  logic all_ones = 0, tx_off = 0, edge_rise = 0;
  logic out_p, out_n;

  zs_line_encoder #(.WIN(WIN)) uut (
    .clk(clk), .rst(rst), .tx_p(tx_p), .tx_n(tx_n), .sel_e3(sel_e3),
    .subst_dis(subst_dis), .dual_rail(dual_rail), .all_ones(all_ones),
    .tx_off(tx_off), .edge_rise(edge_rise), .out_p(out_p), .out_n(out_n)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "R11";

  // reference model: 0 = no pulse, 1 = alternating pulse, 2 = repeat-polarity pulse
  int sym_q[$];
  int raw_q[$];
  int zero_run;
  int odd_marks;
  int last_pol;

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    sym_q.delete();
    raw_q.delete();
    for (int i = 0; i < WIN; i++) begin
      sym_q.push_back(0);
      raw_q.push_back(0);
    end
    zero_run  = WIN;
    odd_marks = 0;
    last_pol  = -1;
  endtask

  function automatic int model_step(input bit sp, input bit sn);
    int b, s, rw, ep, en, runlen, last;
    b = (all_ones || sp) ? 1 : 0;
    runlen = sel_e3 ? 4 : 3;
    sym_q.push_back(b);
    raw_q.push_back({30'd0, sp, sn});
    if (b == 1) begin
      zero_run = 0;
      odd_marks ^= 1;
    end else begin
      zero_run++;
      if (!subst_dis && zero_run >= runlen) begin
        last = sym_q.size() - 1;
        sym_q[last] = 2;
        if (odd_marks == 0) sym_q[last - (runlen - 1)] = 1;
        odd_marks = 0;
        zero_run = 0;
      end
    end
    s  = sym_q.pop_front();
    rw = raw_q.pop_front();
    ep = 0; en = 0;
    if (s == 1) last_pol = -last_pol;
    if (s != 0) begin
      if (last_pol > 0) ep = 1; else en = 1;
    end
    if (tx_off)         return 0;
    else if (dual_rail) return rw;
    else                return ep * 2 + en;
  endfunction

  // one clock: early value up to the falling edge, late value until the rising edge
  task automatic cyc(input bit ep, input bit en, input bit lp, input bit ln);
    int exp, act;
    bit sp, sn;
    tx_p = ep; tx_n = en;
    #4;
    tx_p = lp; tx_n = ln;
    @(posedge clk);
    sp = edge_rise ? lp : ep;
    sn = edge_rise ? ln : en;
    exp = model_step(sp, sn);
    #1;
    act = {30'd0, out_p, out_n};
    check(act == exp, tag, act, exp);
    if (!dual_rail) check(!(out_p && out_n), "R12", act, exp);
  endtask

  task automatic cyc1(input bit p, input bit n);
    cyc(p, n, p, n);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset holds outputs low
    repeat (3) begin
      @(posedge clk); #1;
      check(!out_p && !out_n, "R11", {out_p, out_n}, 0);
    end
    rst = 1'b0;
    model_reset();

    // R3 / R7: first mark after reset is positive and appears after WIN edges
    subst_dis = 1;
    tag = "R7";
    cyc1(1, 0);
    cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);
    check(!out_p && !out_n, "R7 before latency", {out_p, out_n}, 0);
    tag = "R3";
    cyc1(0, 0);
    check(out_p && !out_n, "R3 first mark positive", {out_p, out_n}, 2);
    cyc1(1, 0); cyc1(1, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);

    // R4: plain AMI
    tag = "R4";
    for (int i = 0; i < 40; i++) cyc1($urandom_range(0, 2) == 0, 0);
    for (int i = 0; i < 8; i++) cyc1(0, 0);

    // R1: three-zero substitution, odd and even cases
    subst_dis = 0; sel_e3 = 0;
    tag = "R1";
    cyc1(1, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);
    cyc1(1, 0); cyc1(1, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);
    for (int i = 0; i < 80; i++) cyc1($urandom_range(0, 3) == 0, 0);

    // R2: four-zero substitution
    sel_e3 = 1;
    tag = "R2";
    cyc1(1, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);
    cyc1(1, 0); cyc1(1, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0); cyc1(0, 0);
    for (int i = 0; i < 80; i++) cyc1($urandom_range(0, 3) == 0, 0);

    // R7: switching modes mid-stream keeps state
    tag = "R7";
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 0) sel_e3 = ~sel_e3;
      if (i % 11 == 0) subst_dis = ~subst_dis;
      cyc1($urandom_range(0, 3) == 0, 0);
    end
    subst_dis = 0;

    // R5: negative rail ignored in single-rail mode
    tag = "R5";
    for (int i = 0; i < 40; i++) cyc1($urandom_range(0, 2) == 0, $urandom_range(0, 1));

    // R6: dual-rail passthrough
    dual_rail = 1;
    tag = "R6";
    for (int i = 0; i < 40; i++) cyc1($urandom_range(0, 1), $urandom_range(0, 1));
    dual_rail = 0;
    for (int i = 0; i < 6; i++) cyc1(0, 0);

    // R9: all-ones override with random data
    all_ones = 1;
    tag = "R9";
    for (int i = 0; i < 30; i++) cyc1($urandom_range(0, 1), $urandom_range(0, 1));
    all_ones = 0;

    // R10: transmitter off toggling
    sel_e3 = 0;
    tag = "R10";
    for (int i = 0; i < 40; i++) begin
      tx_off = ($urandom_range(0, 2) == 0);
      cyc1($urandom_range(0, 2) == 0, 0);
    end
    tx_off = 0;

    // R8: edge select with data changing between edges
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      if (i % 5 == 0) edge_rise = ~edge_rise;
      cyc($urandom_range(0, 1), 0, $urandom_range(0, 1), 0);
    end
    edge_rise = 0;
    for (int i = 0; i < 6; i++) cyc1(0, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule